// File: doc/BRIEF.md
# Divide-by-three processor clock generator

This block turns a reference that runs at three times the wanted rate into a processor clock level (CLK) and a peripheral clock level (PCLK). Everything lives in one fast system clock domain. The two references arrive as single-cycle tick enables: one from the crystal path and one from an external source. A select input picks which of the two advances a modulo-3 phase counter. CLK is a registered level that is high for one reference interval out of every three. PCLK toggles on each CLK rise, so it runs at half the CLK rate with even duty.

A synchronization input holds the counter in a waiting state and forces CLK high and PCLK low. Several instances that share the same synchronization pulse therefore leave it in phase. The first reference tick after release, or after reset, arms the counter and starts a period. The select input is taken up only while the counter is waiting or at a period boundary, so switching sources cannot produce a runt pulse. Single-cycle rise and fall strobes let logic in the fast domain act on CLK edges. A registered copy of the crystal tick is always available, whatever the select input says.

The block carries no data stream. Every pin is a plain control or status level, so there is no valid/ready handshake and no back-pressure.

Top module: `refdiv_clkgen`

## Requirements
- R1: While rst_ni is low, cpu_clk_o is 1 and per_clk_o, osc_o, clk_rise_o and clk_fall_o are 0. The counter waits for its first tick, and the latched source is the crystal.
- R2: The first selected tick after reset or after sync_i falls arms the counter. It leaves cpu_clk_o high and pulses no strobe.
- R3: Once the counter is armed, every selected tick advances a three-step cycle. The 1st tick after arming drives cpu_clk_o low, the 2nd keeps it low and the 3rd drives it high, and the pattern then repeats. CLK is high for one tick interval in three.
- R4: per_clk_o inverts on every rise of cpu_clk_o caused by a tick, and on nothing else except sync. Over whole periods it is high half the time.
- R5: When the latched source is 0, xtal_tick_i advances the counter and ext_tick_i is ignored. When it is 1, ext_tick_i advances it and xtal_tick_i is ignored.
- R6: The latched source takes the value of sel_ext_i only in a cycle where the counter is waiting, sync_i is high, or a tick completes a period. At any other time, changes of sel_ext_i are held off.
- R7: A cycle with sync_i high has priority over any tick. In the next cycle cpu_clk_o is 1 and per_clk_o is 0, and the counter returns to waiting.
- R8: osc_o equals xtal_tick_i delayed by one system clock, independent of sel_ext_i.
- R9: clk_rise_o is 1 for exactly the cycle in which cpu_clk_o has just gone from 0 to 1, including a rise forced by sync. clk_fall_o is 1 for exactly the cycle in which it has gone from 1 to 0.
- R10: In a cycle with no tick on either input and sync_i low, cpu_clk_o and per_clk_o keep their values in the next cycle, and both strobes are 0.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk_i | input | 1 | Fast system clock |
| rst_ni | input | 1 | Asynchronous active-low reset |
| xtal_tick_i | input | 1 | Single-cycle tick from the crystal reference |
| ext_tick_i | input | 1 | Single-cycle tick from the external reference |
| sel_ext_i | input | 1 | Source select: 0 crystal, 1 external |
| sync_i | input | 1 | Synchronization hold: CLK high, PCLK low, counter waiting |
| cpu_clk_o | output | 1 | Processor clock level, one-third high |
| per_clk_o | output | 1 | Peripheral clock level, half the CLK rate, 50% duty |
| osc_o | output | 1 | Registered copy of the crystal tick |
| clk_rise_o | output | 1 | One-cycle strobe after a CLK rise |
| clk_fall_o | output | 1 | One-cycle strobe after a CLK fall |

## Verification
The properties assume that every input is synchronous to clk_i and that a tick is a level sampled once per system clock. Back-to-back ticks are legal, and a tick in the same cycle as sync_i is allowed. The stimulus changes inputs only on the falling edge of the system clock and reads outputs one nanosecond after the rising edge. It covers a tick colliding with sync, a select change in the middle of a period, a select change while waiting, and ticks arriving on the non-selected input.

// File: rtl/refdiv_pkg.sv
package refdiv_pkg;
  // Next-cycle view of the processor clock: its level and edge strobes.
  typedef struct packed {
    logic level;
    logic rise;
    logic fall;
  } clk_view_t;
endpackage

// File: rtl/refdiv_src_sel.sv
module refdiv_src_sel (
  input  logic clk_i,
  input  logic rst_ni,
  input  logic xtal_tick_i,
  input  logic ext_tick_i,
  input  logic sel_ext_i,
  input  logic load_i,
  output logic tick_o
);
  logic src_q;

  // Source is only re-latched when the phase logic says it is safe.
  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni)     src_q <= 1'b0;
    else if (load_i) src_q <= sel_ext_i;
  end

  assign tick_o = src_q ? ext_tick_i : xtal_tick_i;
endmodule

// File: rtl/refdiv_phase.sv
module refdiv_phase #(
  parameter int unsigned DIV_RATIO  = 3,
  parameter int unsigned HIGH_TICKS = 1
) (
  input  logic clk_i,
  input  logic rst_ni,
  input  logic tick_i,
  input  logic sync_i,
  output logic level_nxt_o,
  output logic wrap_o,
  output logic sel_load_o
);
  localparam int unsigned CW = (DIV_RATIO > 2) ? $clog2(DIV_RATIO) : 1;
  localparam logic [CW-1:0] LAST  = CW'(DIV_RATIO - 1);
  localparam logic [CW-1:0] HIGHN = CW'(HIGH_TICKS);

  logic          armed_q;
  logic [CW-1:0] phase_q, phase_nxt;
  logic          advance;

  assign advance = tick_i && armed_q && !sync_i;
  assign wrap_o  = advance && (phase_q == LAST);

  always_comb begin
    phase_nxt = phase_q;
    if (sync_i || (tick_i && !armed_q)) phase_nxt = '0;
    else if (advance)                   phase_nxt = wrap_o ? '0 : phase_q + CW'(1);
  end

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      armed_q <= 1'b0;
      phase_q <= '0;
    end else begin
      phase_q <= phase_nxt;
      if (sync_i)      armed_q <= 1'b0;
      else if (tick_i) armed_q <= 1'b1;
    end
  end

  // High for the first HIGH_TICKS tick intervals of each period.
  assign level_nxt_o = sync_i || (phase_nxt < HIGHN);
  assign sel_load_o  = sync_i || !armed_q || wrap_o;
endmodule

// File: rtl/refdiv_outs.sv
module refdiv_outs
  import refdiv_pkg::*;
(
  input  logic clk_i,
  input  logic rst_ni,
  input  logic level_nxt_i,
  input  logic wrap_i,
  input  logic sync_i,
  input  logic xtal_tick_i,
  output logic cpu_clk_o,
  output logic per_clk_o,
  output logic osc_o,
  output logic clk_rise_o,
  output logic clk_fall_o
);
  clk_view_t view_q, view_d;

  always_comb begin
    view_d.level = level_nxt_i;
    view_d.rise  = level_nxt_i && !view_q.level;
    view_d.fall  = !level_nxt_i && view_q.level;
  end

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      view_q    <= '{level: 1'b1, rise: 1'b0, fall: 1'b0};
      per_clk_o <= 1'b0;
      osc_o     <= 1'b0;
    end else begin
      view_q <= view_d;
      osc_o  <= xtal_tick_i;
      if (sync_i)      per_clk_o <= 1'b0;
      else if (wrap_i) per_clk_o <= !per_clk_o;
    end
  end

  assign cpu_clk_o  = view_q.level;
  assign clk_rise_o = view_q.rise;
  assign clk_fall_o = view_q.fall;
endmodule

// File: rtl/refdiv_clkgen.sv
module refdiv_clkgen #(
  parameter int unsigned DIV_RATIO  = 3,
  parameter int unsigned HIGH_TICKS = 1
) (
  input  logic clk_i,
  input  logic rst_ni,
  input  logic xtal_tick_i,
  input  logic ext_tick_i,
  input  logic sel_ext_i,
  input  logic sync_i,
  output logic cpu_clk_o,
  output logic per_clk_o,
  output logic osc_o,
  output logic clk_rise_o,
  output logic clk_fall_o
);
  logic tick, level_nxt, wrap, sel_load;

  refdiv_src_sel u_src (
    .clk_i, .rst_ni, .xtal_tick_i, .ext_tick_i, .sel_ext_i,
    .load_i (sel_load),
    .tick_o (tick)
  );

  refdiv_phase #(.DIV_RATIO(DIV_RATIO), .HIGH_TICKS(HIGH_TICKS)) u_phase (
    .clk_i, .rst_ni, .sync_i,
    .tick_i      (tick),
    .level_nxt_o (level_nxt),
    .wrap_o      (wrap),
    .sel_load_o  (sel_load)
  );

  refdiv_outs u_outs (
    .clk_i, .rst_ni, .sync_i, .xtal_tick_i,
    .level_nxt_i (level_nxt),
    .wrap_i      (wrap),
    .cpu_clk_o, .per_clk_o, .osc_o, .clk_rise_o, .clk_fall_o
  );
endmodule

// File: rtl/refdiv_clkgen_chk.sv
module refdiv_clkgen_chk (
  input logic clk_i,
  input logic rst_ni,
  input logic xtal_tick_i,
  input logic ext_tick_i,
  input logic sel_ext_i,
  input logic sync_i,
  input logic cpu_clk_o,
  input logic per_clk_o,
  input logic osc_o,
  input logic clk_rise_o,
  input logic clk_fall_o
);
  p_sync_hold_r7: assert property (@(posedge clk_i) disable iff (!rst_ni)
    sync_i |=> (cpu_clk_o && !per_clk_o));

  p_rise_edge_r9: assert property (@(posedge clk_i) disable iff (!rst_ni)
    clk_rise_o |-> (cpu_clk_o && !$past(cpu_clk_o)));

  p_fall_edge_r9: assert property (@(posedge clk_i) disable iff (!rst_ni)
    clk_fall_o |-> (!cpu_clk_o && $past(cpu_clk_o)));

  p_idle_stable_r10: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (!sync_i && !xtal_tick_i && !ext_tick_i) |=>
      ($stable(cpu_clk_o) && $stable(per_clk_o) && !clk_rise_o && !clk_fall_o));

  p_osc_copy_r8: assert property (@(posedge clk_i) disable iff (!rst_ni)
    xtal_tick_i |=> osc_o);

  p_osc_quiet_r8: assert property (@(posedge clk_i) disable iff (!rst_ni)
    !xtal_tick_i |=> !osc_o);

  p_pclk_at_rise_r4: assert property (@(posedge clk_i) disable iff (!rst_ni)
    !$stable(per_clk_o) |-> (clk_rise_o || $past(sync_i)));
endmodule

bind refdiv_clkgen refdiv_clkgen_chk u_chk (.*);

// File: tb/refdiv_clkgen_bench.sv
module refdiv_clkgen_bench;
  logic clk_i = 1'b0, rst_ni = 1'b0;
  logic xtal_tick_i = 1'b0, ext_tick_i = 1'b0, sel_ext_i = 1'b0, sync_i = 1'b0;
  logic cpu_clk_o, per_clk_o, osc_o, clk_rise_o, clk_fall_o;
  int n_chk = 0, n_bad = 0;
  bit done = 1'b0;

  always #2 clk_i = ~clk_i;

  refdiv_clkgen u_refdiv_clkgen (.*);

  // {sync, sel, xtal, ext} -> expected {cpu, per, rise, fall, osc}
  localparam int NV = 22;
  localparam logic [8:0] VEC [NV] = '{
    9'b1000_10000, // R7 sync
    9'b0010_10001, // R2 arm, no edge
    9'b0000_10000, // R10 idle
    9'b0010_00011, // R3 fall
    9'b0001_00000, // R5 ext ignored
    9'b0010_00001, // R3 stay low
    9'b0010_11101, // R3 rise, R4 toggle
    9'b0010_01011,
    9'b0110_01001, // R6 select request mid period
    9'b0101_01000, // R6 ext still ignored
    9'b0110_10101, // boundary: source latched
    9'b0110_10001, // R5 xtal ignored, R8 osc still follows
    9'b0101_00010,
    9'b0101_00000,
    9'b0101_11100,
    9'b1101_10000, // R7 sync clears per
    9'b0000_10000, // R6 select taken while waiting
    9'b0001_10000, // R5
    9'b0010_10001, // R2
    9'b0010_00011,
    9'b1010_10101, // R7 sync wins over tick, R9 rise
    9'b0000_10000
  };

  task automatic chk(input string req, input logic act, input logic exp);
    n_chk++;
    if (act !== exp) begin
      n_bad++;
      $display("FAIL %s actual=%b expected=%b at %0t", req, act, exp, $time);
    end
  endtask

  task automatic step(input logic s, input logic sel, input logic x, input logic e);
    @(negedge clk_i);
    sync_i = s; sel_ext_i = sel; xtal_tick_i = x; ext_tick_i = e;
    @(posedge clk_i);
    #1;
  endtask

  task automatic summary;
    if (!done) begin
      done = 1'b1;
      $display("  == %0d vectors applied, %0d miscompares ==", n_chk, n_bad);
      $finish;
    end
  endtask

  initial begin
    #(200000 * 4);
    n_bad++;
    $display("FAIL watchdog expired");
    summary();
  end

  initial begin
    int rises, highs, phigh;
    #5;
    chk("R1 cpu", cpu_clk_o, 1'b1);
    chk("R1 per", per_clk_o, 1'b0);
    chk("R1 osc", osc_o, 1'b0);
    chk("R1 rise", clk_rise_o, 1'b0);
    chk("R1 fall", clk_fall_o, 1'b0);
    @(negedge clk_i) rst_ni = 1'b1;

    for (int i = 0; i < NV; i++) begin
      step(VEC[i][8], VEC[i][7], VEC[i][6], VEC[i][5]);
      chk("R3 cpu", cpu_clk_o,  VEC[i][4]);
      chk("R4 per", per_clk_o,  VEC[i][3]);
      chk("R9 rise", clk_rise_o, VEC[i][2]);
      chk("R9 fall", clk_fall_o, VEC[i][1]);
      chk("R8 osc", osc_o,      VEC[i][0]);
    end

    // R1: reset in the middle of a low phase
    step(0, 0, 1, 0);
    step(0, 0, 1, 0);
    chk("R3 low before reset", cpu_clk_o, 1'b0);
    @(negedge clk_i) rst_ni = 1'b0; xtal_tick_i = 1'b0;
    #1;
    chk("R1 cpu async", cpu_clk_o, 1'b1);
    chk("R1 per async", per_clk_o, 1'b0);
    @(negedge clk_i) rst_ni = 1'b1;

    // R2 R3 R4: long run, 1 arming tick then 30 ticks
    step(1, 0, 0, 0);
    step(0, 0, 1, 0);
    chk("R2 armed high", cpu_clk_o, 1'b1);
    rises = 0; highs = 0; phigh = 0;
    for (int t = 0; t < 30; t++) begin
      step(0, 0, 1, 0);
      rises += int'(clk_rise_o);
      highs += int'(cpu_clk_o);
      phigh += int'(per_clk_o);
      step(0, 0, 0, 0);
    end
    chk("R3 rise count", rises == 10, 1'b1);
    chk("R3 one-third high", highs == 10, 1'b1);
    chk("R4 half duty", phigh == 15, 1'b1);
    chk("R4 even toggles", per_clk_o, 1'b0);

    // R5: external source after a waiting re-latch
    step(1, 1, 0, 0);
    step(0, 1, 0, 1);
    step(0, 1, 1, 0);
    chk("R5 xtal ignored", cpu_clk_o, 1'b1);
    step(0, 1, 0, 1);
    chk("R5 ext drives fall", clk_fall_o, 1'b1);
    summary();
  end
endmodule